// File: doc/BRIEF.md
# Core-Side Lock Endpoint

This block sits beside a processor core and gives software a hardware path to a small set of highly contended locks. For each lock it holds two software-visible bits. One is an acquire bit that software sets and then polls. The other is a release bit that software sets when it leaves the critical section. The block turns accepted writes into single-cycle pulses on one outgoing 1-bit line per lock. That line goes toward a group lock manager, and the manager tells a request from a release by looking at its own per-core flag.

When the manager's grant pulse (the token) comes back, the block clears the acquire bit in hardware. Software reads that cleared bit as "lock held". The release bit also clears itself, one cycle after the release pulse has gone out. By then the manager's flag for this core has been cleared.

Each lock runs an independent four-state machine: idle, waiting, holding and releasing. The state of every lock is reported on a status output.

Top module: `lockep_top`

## Requirements
- R1: After reset every acquire bit, release bit and outgoing line is 0, and every lock's status reads idle (2'b00).
- R2: An acquire write to an idle lock sets its acquire bit and its outgoing line one cycle later, and the status becomes waiting (2'b01).
- R3: A token pulse while waiting clears the acquire bit one cycle later, and the status becomes holding (2'b10).
- R4: A release write to a holding lock sets its release bit and its outgoing line one cycle later, and the status becomes releasing (2'b11).
- R5: Each accepted write produces exactly one outgoing pulse, one cycle wide; rejected writes produce none.
- R6: The release bit clears one cycle after it was set, and the status then returns to idle.
- R7: An acquire write to a lock that is not idle has no effect on its bits, line or status.
- R8: A release write to a lock that is not holding has no effect on its bits, line or status.
- R9: A token pulse to a lock that is not waiting has no effect.
- R10: Locks are independent: stimulus on one lock never changes another lock's outputs.
- R11: When the token arrives in the cycle after the request pulse is visible, the acquire bit reads 0 two clock edges after the acquire write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_wr_i | input | NUM_LOCKS | Software write of 1 to a lock's acquire bit |
| rel_wr_i | input | NUM_LOCKS | Software write of 1 to a lock's release bit |
| token_i | input | NUM_LOCKS | Grant pulse from the manager, per lock |
| acq_bit_o | output | NUM_LOCKS | Readback of the acquire bits |
| rel_bit_o | output | NUM_LOCKS | Readback of the release bits |
| line_o | output | NUM_LOCKS | Shared request/release pulse line, per lock |
| status_o | output | 2*NUM_LOCKS | Per-lock state: 00 idle, 01 waiting, 10 holding, 11 releasing |

## Verification
A corrupted state register shows on status_o at the next sampling point, because status is the state itself. It also shows as a wrong reaction to the next write or token. For example, a lock that is wrongly left in holding would accept a release and pulse the line when it should not.

A lost clear of the acquire bit would hang software polling that bit. The bench sees it one cycle after the token.

A pulse held longer than one cycle would be decoded by the manager as a second event. This is caught on the cycle after any pulse.

// File: rtl/lockep_pkg.sv
package lockep_pkg;

  typedef enum logic [1:0] {
    EP_IDLE = 2'b00,
    EP_WAIT = 2'b01,
    EP_HOLD = 2'b10,
    EP_RELS = 2'b11
  } ep_state_t;

  // Next state of one lock endpoint.
  function automatic ep_state_t ep_next(input ep_state_t cur,
                                        input logic acq_wr,
                                        input logic rel_wr,
                                        input logic token);
    ep_state_t nxt;
    nxt = cur;
    unique case (cur)
      EP_IDLE: if (acq_wr) nxt = EP_WAIT;
      EP_WAIT: if (token)  nxt = EP_HOLD;
      EP_HOLD: if (rel_wr) nxt = EP_RELS;
      EP_RELS: nxt = EP_IDLE;
      default: nxt = EP_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/lockep_pulse.sv
module lockep_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic line_o
);

  logic line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= fire_i;
  end

  assign line_o = line_q;

endmodule

// File: rtl/lockep_slot.sv
module lockep_slot
  import lockep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acq_wr_i,
  input  logic      rel_wr_i,
  input  logic      token_i,
  output logic      acq_bit_o,
  output logic      rel_bit_o,
  output logic      line_o,
  output logic [1:0] status_o
);

  ep_state_t state_q, state_d;
  logic      acq_q, rel_q;

  // Named internal events
  logic acc_acq, acc_rel, acc_tok, rel_done, fire;

  assign acc_acq  = (state_q == EP_IDLE) && acq_wr_i;
  assign acc_tok  = (state_q == EP_WAIT) && token_i;
  assign acc_rel  = (state_q == EP_HOLD) && rel_wr_i;
  assign rel_done = (state_q == EP_RELS);
  assign fire     = acc_acq | acc_rel;

  assign state_d = ep_next(state_q, acq_wr_i, rel_wr_i, token_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EP_IDLE;
      acq_q   <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_acq)      acq_q <= 1'b1;
      else if (acc_tok) acq_q <= 1'b0;
      if (acc_rel)       rel_q <= 1'b1;
      else if (rel_done) rel_q <= 1'b0;
    end
  end

  lockep_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .line_o (line_o)
  );

  assign acq_bit_o = acq_q;
  assign rel_bit_o = rel_q;
  assign status_o  = state_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_o |=> !line_o); // R5
  AST_ACQ_SETS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_q) |-> line_o); // R2
  AST_TOKEN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tok |=> (!acq_q && state_q == EP_HOLD)); // R3
  AST_REL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> (!rel_q && state_q == EP_IDLE)); // R6
  AST_REL_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> ($past(state_q) == EP_HOLD && line_o)); // R8
  AST_ACQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_wr_i && state_q != EP_IDLE) |=> !line_o || $past(acc_rel)); // R7

endmodule

// File: rtl/lockep_top.sv
module lockep_top #(
  parameter int NUM_LOCKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LOCKS-1:0]   acq_wr_i,
  input  logic [NUM_LOCKS-1:0]   rel_wr_i,
  input  logic [NUM_LOCKS-1:0]   token_i,
  output logic [NUM_LOCKS-1:0]   acq_bit_o,
  output logic [NUM_LOCKS-1:0]   rel_bit_o,
  output logic [NUM_LOCKS-1:0]   line_o,
  output logic [2*NUM_LOCKS-1:0] status_o
);

  localparam int STW = 2;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    lockep_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .acq_wr_i  (acq_wr_i[g]),
      .rel_wr_i  (rel_wr_i[g]),
      .token_i   (token_i[g]),
      .acq_bit_o (acq_bit_o[g]),
      .rel_bit_o (rel_bit_o[g]),
      .line_o    (line_o[g]),
      .status_o  (status_o[g*STW +: STW])
    );
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && line_o == '0 && acq_bit_o == '0)); // R1

endmodule

// File: tb/lockep_top_tb_top.sv
`timescale 1ns/1ps
module lockep_top_tb_top;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   acq_wr = '0, rel_wr = '0, token = '0;
  logic [N-1:0]   acq_bit, rel_bit, line;
  logic [2*N-1:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lockep_top #(.NUM_LOCKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_wr_i(acq_wr), .rel_wr_i(rel_wr),
    .token_i(token), .acq_bit_o(acq_bit), .rel_bit_o(rel_bit),
    .line_o(line), .status_o(status)
  );

  task automatic cyc();
    @(posedge clk); #1;
    acq_wr = '0; rel_wr = '0; token = '0;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int st(int i);
    return int'(status[2*i +: 2]);
  endfunction

  // Compare one lock's full observable state
  task automatic view(string tag, int i, int a, int r, int l, int s);
    chk({tag, " acq"}, int'(acq_bit[i]), a);
    chk({tag, " rel"}, int'(rel_bit[i]), r);
    chk({tag, " line"}, int'(line[i]), l);
    chk({tag, " status"}, st(i), s);
  endtask

  task automatic t_reset();
    chk("R1 status all", int'(status), 0);
    chk("R1 line all", int'(line), 0);
    chk("R1 acq all", int'(acq_bit), 0);
    chk("R1 rel all", int'(rel_bit), 0);
  endtask

  task automatic t_best_acquire(int i);
    acq_wr[i] = 1'b1; cyc();
    view("R2 request", i, 1, 0, 1, 1);
    token[i] = 1'b1; cyc();
    view("R11 R3 granted", i, 0, 0, 0, 2);
  endtask

  task automatic t_ignored_in_hold(int i);
    acq_wr[i] = 1'b1; cyc();
    view("R7 acq in hold", i, 0, 0, 0, 2);
    token[i] = 1'b1; cyc();
    view("R9 token in hold", i, 0, 0, 0, 2);
  endtask

  task automatic t_release(int i);
    rel_wr[i] = 1'b1; cyc();
    view("R4 release", i, 0, 1, 1, 3);
    rel_wr[i] = 1'b1; cyc();
    view("R6 R8 rel cleared", i, 0, 0, 0, 0);
  endtask

  task automatic t_idle_ignores(int i);
    rel_wr[i] = 1'b1; cyc();
    view("R8 rel in idle", i, 0, 0, 0, 0);
    token[i] = 1'b1; cyc();
    view("R9 token in idle", i, 0, 0, 0, 0);
  endtask

  task automatic t_slow_grant(int i);
    acq_wr[i] = 1'b1; cyc();
    view("R2 request slow", i, 1, 0, 1, 1);
    acq_wr[i] = 1'b1; cyc();
    view("R7 R5 dup acq", i, 1, 0, 0, 1);
    rel_wr[i] = 1'b1; cyc();
    view("R8 rel in wait", i, 1, 0, 0, 1);
    cyc();
    view("R3 still waiting", i, 1, 0, 0, 1);
    token[i] = 1'b1; cyc();
    view("R3 late grant", i, 0, 0, 0, 2);
  endtask

  task automatic t_independent();
    acq_wr[2] = 1'b1; cyc();
    view("R10 lock2 req", 2, 1, 0, 1, 1);
    view("R10 lock1 held", 1, 0, 0, 0, 2);
    view("R10 lock3 idle", 3, 0, 0, 0, 0);
    token[1] = 1'b1; rel_wr[3] = 1'b1; cyc();
    view("R10 lock2 unaffected", 2, 1, 0, 0, 1);
    token[2] = 1'b1; cyc();
    view("R10 lock2 held", 2, 0, 0, 0, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_best_acquire(0);
    t_ignored_in_hold(0);
    t_release(0);
    t_idle_ignores(0);
    t_slow_grant(1);
    t_independent();
    t_release(1);
    t_release(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule